// File: doc/BRIEF.md
# Infrared Pulse-Width Capture Queue

The block watches a demodulated infrared receiver line and measures each stretch of constant level. The measurement unit is one strobe of an external 10 µs timebase. A width is queued whenever the line changes level, and also when the line has been quiet for longer than a programmed idle limit while a measurement was running. Software reads the queued widths one word at a time through a pop port.

Two sticky flags can raise the interrupt. The first is set when the queue fill reaches a programmed pulse count. The second is set when the line goes idle. A configuration word selects which flags may reach the interrupt, and a two-bit mask allows software to silence both flags while it drains the queue. Flags are cleared by writing ones to their status positions. A separate run input stops capture while software handles a frame.

The configuration word resets to: capture on, both sources selected, a threshold of 80 pulses and an idle limit of 5000 ticks.

Top module: `ir_width_fifo`

## Requirements
- R1: After reset, `status` reads 32'h0800_0000, which is the empty flag at bit 27 with a fill of zero, and `irq` is low.
- R2: Capture starts only after the first level change following enable, so that first change queues nothing. Each later change queues the number of `tick` strobes seen since the previous change, in bits 12:0 of `rd_data`.
- R3: A width that arrives while the queue holds DEPTH entries is discarded and sets the sticky overflow flag at status bit 26. Writing a one to bit 26 clears that flag.
- R4: When `rd_en` is asserted with the queue empty, `rd_data` is zero and the fill count in `status[15:0]` does not change.
- R5: When the idle count reaches the limit in configuration bits 12:0 (a limit of zero disables it), the timeout flag at status bit 29 is set. If a measurement is running, the limit value is queued as its width. The timeout fires only once per idle period.
- R6: A push that brings the fill count equal to the threshold in configuration bits 20:13 sets the pending flag at status bit 30.
- R7: Writing ones to status bits 30 and 29 clears the pending flag and the timeout flag. A zero written to either bit leaves that flag unchanged.
- R8: `irq` is the OR of two terms: pending AND configuration bit 21 AND `irq_en[0]`, and timeout AND configuration bit 22 AND `irq_en[1]`.
- R9: While `run_en` is low or configuration bit 31 is clear, level changes and strobes queue nothing.
- R10: The width count saturates at 8191 and does not wrap.
- R11: Widths are read back in the order they were queued, and `status[15:0]` always gives the current fill.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick | input | 1 | One-cycle strobe of the 10 µs timebase |
| ir_in | input | 1 | Demodulated receiver line (asynchronous) |
| run_en | input | 1 | Capture run control |
| irq_en | input | 2 | Interrupt mask: bit 0 pending, bit 1 timeout |
| cfg_we | input | 1 | Write `wdata` into the configuration word |
| sts_we | input | 1 | Write-one-to-clear strobe for status bits 30, 29, 26 |
| wdata | input | 32 | Write data for configuration and status clear |
| rd_en | input | 1 | Pop one width |
| rd_data | output | 32 | Head width in bits 12:0, zero when empty |
| status | output | 32 | 30 pending, 29 timeout, 27 empty, 26 overflow, 15:0 fill |
| irq | output | 1 | Interrupt request |

## Verification
The properties take `tick` to be a one-cycle strobe and take the status-clear strobe to touch only the flag bits. They do not rely on the exact timing of `ir_in`, because the line passes through a synchronizer. To keep each edge from landing in the same cycle as a strobe, the stimulus leaves `tick` low for four cycles after every change of `ir_in`. Each expected width is therefore the exact number of strobes that the bench issued.

// File: rtl/ir_width_fifo.sv
`timescale 1ns/1ps
module ir_width_fifo #(
  parameter int DEPTH = 128,
  parameter logic [31:0] CFG_RST = 32'h8000_0000 | (32'd3 << 21) | (32'd80 << 13) | 32'd5000
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        tick,
  input  logic        ir_in,
  input  logic        run_en,
  input  logic [1:0]  irq_en,
  input  logic        cfg_we,
  input  logic        sts_we,
  input  logic [31:0] wdata,
  input  logic        rd_en,
  output logic [31:0] rd_data,
  output logic [31:0] status,
  output logic        irq
);
  localparam int WW = 13;
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int LW = AW + 1;

  logic [31:0]   cfg;
  logic          s1, s2, lvl, meas, fired;
  logic [WW-1:0] cnt;
  logic [WW-1:0] mem [DEPTH];
  logic [AW-1:0] wp, rp;
  logic [LW-1:0] fill;
  logic          pend, tmo, ovf;

  wire active  = cfg[31] & run_en;
  wire edge_d  = active & (s2 != lvl);
  wire [WW-1:0] cnt_inc = (&cnt) ? cnt : cnt + 1'b1;
  wire [WW-1:0] tmo_val = cfg[12:0];
  wire [7:0]    thr     = cfg[20:13];
  wire tmo_hit = active & ~edge_d & tick & ~fired & (tmo_val != '0) & (cnt_inc == tmo_val);
  wire push_req = meas & (edge_d | tmo_hit);
  wire [WW-1:0] push_val = edge_d ? cnt : cnt_inc;
  wire full    = (fill == LW'(DEPTH));
  wire empty   = (fill == '0);
  wire do_push = push_req & ~full;
  wire do_pop  = rd_en & ~empty;
  wire [LW-1:0] fill_n = fill + LW'(do_push) - LW'(do_pop);
  wire pend_set = do_push & (thr != 8'd0) & (16'(fill_n) == {8'd0, thr});
  wire unused_cfg = ^cfg[30:23];

  assign rd_data = empty ? 32'd0 : {19'd0, mem[rp]};
  assign status  = {1'b0, pend, tmo, 1'b0, empty, ovf, 10'd0, 16'(fill)};
  assign irq     = (pend & cfg[21] & irq_en[0]) | (tmo & cfg[22] & irq_en[1]);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg <= CFG_RST;
      s1 <= 1'b0; s2 <= 1'b0; lvl <= 1'b0;
      meas <= 1'b0; fired <= 1'b0; cnt <= '0;
    end else begin
      if (cfg_we) cfg <= wdata;
      s1 <= ir_in;
      s2 <= s1;
      if (!active) begin
        lvl <= s2; meas <= 1'b0; fired <= 1'b0; cnt <= '0;
      end else if (edge_d) begin
        lvl <= s2; meas <= 1'b1; fired <= 1'b0; cnt <= '0;
      end else if (tick) begin
        cnt <= cnt_inc;
        if (tmo_hit) begin
          fired <= 1'b1;
          meas  <= 1'b0;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp <= '0; rp <= '0; fill <= '0;
      pend <= 1'b0; tmo <= 1'b0; ovf <= 1'b0;
    end else begin
      if (do_push) wp <= (wp == AW'(DEPTH - 1)) ? '0 : wp + 1'b1;
      if (do_pop)  rp <= (rp == AW'(DEPTH - 1)) ? '0 : rp + 1'b1;
      fill <= fill_n;
      if (pend_set) pend <= 1'b1;
      else if (sts_we && wdata[30]) pend <= 1'b0;
      if (tmo_hit) tmo <= 1'b1;
      else if (sts_we && wdata[29]) tmo <= 1'b0;
      if (push_req && full) ovf <= 1'b1;
      else if (sts_we && wdata[26]) ovf <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (do_push) mem[wp] <= push_val;
  end
endmodule

// File: rtl/ir_width_fifo_chk.sv
`timescale 1ns/1ps
module ir_width_fifo_chk #(
  parameter int DEPTH = 128
) (
  input logic        clk,
  input logic        rst_n,
  input logic        run_en,
  input logic [1:0]  irq_en,
  input logic        sts_we,
  input logic [31:0] wdata,
  input logic        rd_en,
  input logic [31:0] rd_data,
  input logic [31:0] status,
  input logic        irq
);
  p_empty_read_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && status[27]) |-> (rd_data == 32'd0));

  p_fill_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (32'(status[15:0]) <= DEPTH));

  p_ovf_sticky_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (status[26] && !(sts_we && wdata[26])) |=> status[26]);

  p_tmo_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (status[29] && !(sts_we && wdata[29])) |=> status[29]);

  p_pend_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (status[30] && !(sts_we && wdata[30])) |=> status[30]);

  p_irq_source_r8: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> ((status[30] && irq_en[0]) || (status[29] && irq_en[1])));

  p_fill_step_r11: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((status[15:0] == $past(status[15:0])) ||
              (status[15:0] == $past(status[15:0]) + 16'd1) ||
              (status[15:0] + 16'd1 == $past(status[15:0]))));

  p_no_capture_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !run_en |=> (status[15:0] <= $past(status[15:0])));
endmodule

bind ir_width_fifo ir_width_fifo_chk #(.DEPTH(DEPTH)) chk_i (.*);

// File: tb/ir_width_fifo_tb_top.sv
`timescale 1ns/1ps
module ir_width_fifo_tb_top;
  localparam int DEPTH = 8;
  localparam logic [31:0] CFG = 32'h8000_0000 | (32'd3 << 21) | (32'd4 << 13) | 32'd50;

  logic clk = 1'b0;
  logic rst_n = 1'b0, tick = 1'b0, ir_in = 1'b0, run_en = 1'b1;
  logic [1:0] irq_en = 2'b00;
  logic cfg_we = 1'b0, sts_we = 1'b0, rd_en = 1'b0;
  logic [31:0] wdata = '0;
  logic [31:0] rd_data, status;
  logic irq;

  int checks = 0, errors = 0;
  bit done = 1'b0;
  logic [12:0] exp_q[$];

  always #2.5 clk = ~clk;

  ir_width_fifo #(.DEPTH(DEPTH)) dut_i (.*);

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic ticks(int n);
    repeat (n) begin @(negedge clk); tick = 1'b1; end
    @(negedge clk); tick = 1'b0;
  endtask

  task automatic toggle_ir();
    @(negedge clk); ir_in = ~ir_in;
    repeat (4) @(negedge clk);
  endtask

  // driver: one measured width, expected value queued if it fits
  task automatic drv_width(int n);
    ticks(n);
    toggle_ir();
    if (exp_q.size() < DEPTH) exp_q.push_back((n > 8191) ? 13'd8191 : 13'(n));
  endtask

  // monitor: pops the design and compares against the scoreboard
  task automatic drain(string req);
    @(negedge clk);
    while (!status[27]) begin
      if (exp_q.size() == 0) begin
        chk({req, " extra entry"}, rd_data, 32'hxxxx_xxxx);
        break;
      end
      chk(req, rd_data, {19'd0, exp_q.pop_front()});
      rd_en = 1'b1;
      @(negedge clk);
      rd_en = 1'b0;
    end
    chk({req, " scoreboard empty"}, exp_q.size(), 0);
  endtask

  task automatic wr_sts(logic [31:0] v);
    @(negedge clk); wdata = v; sts_we = 1'b1;
    @(negedge clk); sts_we = 1'b0;
  endtask

  task automatic wr_cfg(logic [31:0] v);
    @(negedge clk); wdata = v; cfg_we = 1'b1;
    @(negedge clk); cfg_we = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 status", status, 32'h0800_0000);
    chk("R1 irq", irq, 1'b0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 after release", status, 32'h0800_0000);
    wr_cfg(CFG);

    // R2/R6: first edge starts measuring, four widths reach threshold
    toggle_ir();
    chk("R2 first edge queues nothing", status[15:0], 0);
    drv_width(5); drv_width(9); drv_width(3); drv_width(12);
    chk("R6 pending at threshold", status, 32'h4000_0004);
    irq_en = 2'b01;
    @(negedge clk);
    chk("R8 pending irq", irq, 1'b1);

    // R5: idle timeout queues the limit once
    ticks(50);
    exp_q.push_back(13'd50);
    chk("R5 timeout flag and push", status, 32'h6000_0005);
    ticks(60);
    chk("R5 fires once", status, 32'h6000_0005);
    drain("R11 order");

    // R7/R8: write-one-to-clear and masking
    wr_sts(32'h0);
    chk("R7 zero write keeps flags", status, 32'h6800_0000);
    irq_en = 2'b00; @(negedge clk);
    chk("R8 masked", irq, 1'b0);
    wr_sts(32'h4000_0000);
    chk("R7 clear pending only", status, 32'h2800_0000);
    irq_en = 2'b10; @(negedge clk);
    chk("R8 timeout irq", irq, 1'b1);
    irq_en = 2'b01; @(negedge clk);
    chk("R8 pending masked off", irq, 1'b0);
    wr_sts(32'h2000_0000);
    chk("R7 clear timeout", status, 32'h0800_0000);

    // R10: saturation with timeout disabled
    wr_cfg(CFG & ~32'h1FFF);
    toggle_ir();
    drv_width(8200);
    drain("R10 saturated width");

    // R9: capture stopped
    run_en = 1'b0;
    toggle_ir(); ticks(5); toggle_ir();
    chk("R9 nothing queued while stopped", status[15:0], 0);
    run_en = 1'b1;
    toggle_ir();
    chk("R9 restart edge queues nothing", status[15:0], 0);
    drv_width(7);
    chk("R2 one entry", status[15:0], 1);
    drain("R2 width after restart");

    // R3: overflow
    wr_sts(32'h4000_0000);
    for (int i = 0; i < 10; i++) drv_width(i + 1);
    chk("R3 overflow flag and fill", status & 32'h0400_FFFF, 32'h0400_0008);
    drain("R3 kept entries");
    chk("R3 overflow sticky", status[26], 1'b1);
    wr_sts(32'h0400_0000);
    chk("R3 overflow cleared", status[26], 1'b0);

    // R4: read from empty
    @(negedge clk); rd_en = 1'b1;
    #0.1;
    chk("R4 empty read data", rd_data, 32'd0);
    @(negedge clk); rd_en = 1'b0;
    chk("R4 fill unchanged", status[15:0], 0);
    drv_width(3);
    drain("R4 pointers intact");

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule